// File: doc/BRIEF.md
# Limited-pointer coherence directory controller

This block is the directory at a home memory node. For each memory block it owns, it keeps a protocol state, a small fixed set of hardware sharer pointers, an acknowledgment counter, a trap-on-write mode bit and a stall flag. It accepts one coherence message per cycle over a valid/ready handshake, updates the addressed entry, and emits at most one reply per cycle: read data, write data, invalidate or busy.

The common case is handled entirely in hardware. A read that would need more pointers than the entry has raises a trap to the local processor. The entry is then stalled until the software handler resumes it. After such an overflow the entry is placed in trap-on-write mode, so the next write is also handed to software. The handler finishes a write by sending a handler-write message, which puts the entry into the write transaction. Writes that must invalidate several sharers emit their invalidates one per cycle, and input is held off while they go out.

Message codes on `req_type`: 0 read request, 1 write request, 2 replace-modified, 3 update, 4 invalidate acknowledge, 5 handler resume, 6 handler write; 7 is ignored. Reply codes on `rsp_type`: 0 read data, 1 write data, 2 invalidate, 3 busy. Entry states are read-only, read-write, read transaction and write transaction. The requester of a transaction, or the owner in read-write, is held in pointer slot 0.

Top module: `lptr_dir`

## Requirements
- R1: After reset every entry is read-only with no sharers, normal mode and not stalled. `req_ready` is 1 and neither `rsp_valid` nor `trap_valid` is set.
- R2: A read request (0) to a read-only entry from a node that is already a sharer, or when a pointer slot is free, returns read data (0) to that node on the edge that accepts it. In the second case the node is added in the lowest free slot.
- R3: A write request (1) to a read-only entry in normal mode whose sharer set is empty or holds only the requester returns write data (1) on the accepting edge. The entry becomes read-write with the requester as owner.
- R4: A write request to a read-only entry in normal mode with other sharers does four things:
  - it sets the sharer set to the requester;
  - it loads the counter with the number of other sharers;
  - it enters the write transaction;
  - it sends one invalidate (2) per other sharer, in ascending slot order, on the edges that follow the accepting edge.

  `req_ready` is 0 from the accepting edge until the edge that sends the last invalidate.
- R5: In read-write, a read or write request from a node other than the owner sends an invalidate to the owner on the accepting edge. It makes the requester the new pointer, loads the counter with 1 and enters the read or the write transaction. A request from the owner returns read or write data with no change.
- R6: Replace-modified (2) from the owner of a read-write entry empties the sharer set and returns the entry to read-only. From any other node it is ignored.
- R7: In either transaction state, read and write requests are answered with busy (3) and replace-modified is ignored.
- R8: In the write transaction, an acknowledge (4) decrements the counter while the counter is above 1. An acknowledge when the counter is 1 or less, or an update (3), clears the counter, sends write data to the requester and enters read-write.
- R9: In the read transaction, an acknowledge or an update sends read data to the requester. The entry becomes read-only with the requester as its only sharer.
- R10: A read request to a read-only entry with no free slot, from a node that is not a sharer, sends no reply. It pulses `trap_valid` with `trap_write`=0 and the requester and block, empties the entry's pointers, sets trap-on-write mode and stalls the entry.
- R11: While an entry is stalled, read and write requests get busy and other protocol messages are ignored. Handler resume (5) clears the stall.
- R12: A write request to a read-only entry in trap-on-write mode sends no reply. It pulses `trap_valid` with `trap_write`=1 and stalls the entry. Handler write (6) puts the entry into the write transaction with `req_node` as requester and `req_cnt` in the counter, in normal mode and not stalled.
- R13: Messages to one block do not affect any other block's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming message valid |
| req_ready | output | 1 | Message accepted when high with valid |
| req_type | input | 3 | Message code |
| req_node | input | $clog2(NODES) | Sending node |
| req_blk | input | $clog2(BLOCKS) | Addressed block |
| req_cnt | input | $clog2(NODES+1) | Acknowledge count for handler write |
| rsp_valid | output | 1 | Reply valid for one cycle |
| rsp_type | output | 2 | Reply code |
| rsp_node | output | $clog2(NODES) | Destination node of the reply |
| rsp_blk | output | $clog2(BLOCKS) | Block of the reply |
| trap_valid | output | 1 | One-cycle trap pulse to the local processor |
| trap_write | output | 1 | Trap was caused by a write request |
| trap_node | output | $clog2(NODES) | Requester that caused the trap |
| trap_blk | output | $clog2(BLOCKS) | Block that trapped |

## Verification
Replies and traps that a message causes directly are registered once, so they are visible on the edge that accepts the message. The bench samples them at the falling edge that follows that edge. Queued invalidates appear on the following edges, one per edge, and the bench reads one per falling edge, also checking that input stays held off until the last has gone. Every message is sent only when `req_ready` is seen high at a falling edge, so no check depends on ordering at the active edge.

// File: rtl/lptr_dir.sv
`timescale 1ns/1ps
module lptr_dir #(
  parameter int NODES  = 16,
  parameter int BLOCKS = 8,
  parameter int PTRS   = 4,
  localparam int NW = $clog2(NODES),
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int CW = $clog2(NODES + 1),
  localparam int PW = (PTRS > 1) ? $clog2(PTRS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_type,
  input  logic [NW-1:0] req_node,
  input  logic [BW-1:0] req_blk,
  input  logic [CW-1:0] req_cnt,
  output logic          rsp_valid,
  output logic [1:0]    rsp_type,
  output logic [NW-1:0] rsp_node,
  output logic [BW-1:0] rsp_blk,
  output logic          trap_valid,
  output logic          trap_write,
  output logic [NW-1:0] trap_node,
  output logic [BW-1:0] trap_blk
);
  localparam logic [1:0] S_RO = 2'd0, S_RW = 2'd1, S_RT = 2'd2, S_WT = 2'd3;
  localparam logic [2:0] M_RD = 3'd0, M_WR = 3'd1, M_REPM = 3'd2, M_UPD = 3'd3,
                         M_ACK = 3'd4, M_RES = 3'd5, M_SWW = 3'd6;
  localparam logic [1:0] R_RDATA = 2'd0, R_WDATA = 2'd1, R_INV = 2'd2, R_BUSY = 2'd3;

  logic [1:0]      st_q   [BLOCKS];
  logic [PTRS-1:0] vld_q  [BLOCKS];
  logic [NW-1:0]   ptr_q  [BLOCKS][PTRS];
  logic [CW-1:0]   cnt_q  [BLOCKS];
  logic [BLOCKS-1:0] tow_q, stall_q;

  logic [PTRS-1:0] pend_q;
  logic [NW-1:0]   pnode_q [PTRS];
  logic [BW-1:0]   pblk_q;

  logic [PTRS-1:0] cur_vld, is_me, others;
  logic [PW-1:0]   free_idx, pidx;
  logic            has_free;
  logic [CW-1:0]   n_oth;
  logic [NW-1:0]   owner;
  logic            is_req;

  assign req_ready = ~|pend_q;
  assign cur_vld   = vld_q[req_blk];
  assign owner     = ptr_q[req_blk][0];
  assign is_req    = (req_type == M_RD) || (req_type == M_WR);

  always_comb begin
    free_idx = '0;
    has_free = 1'b0;
    pidx     = '0;
    n_oth    = '0;
    for (int k = PTRS - 1; k >= 0; k--) begin
      if (!cur_vld[k]) begin
        free_idx = PW'(k);
        has_free = 1'b1;
      end
      if (pend_q[k]) pidx = PW'(k);
    end
    for (int k = 0; k < PTRS; k++) begin
      is_me[k]  = cur_vld[k] && (ptr_q[req_blk][k] == req_node);
      others[k] = cur_vld[k] && !is_me[k];
      n_oth     = n_oth + CW'(others[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st_q[b]  <= S_RO;
        vld_q[b] <= '0;
        cnt_q[b] <= '0;
        for (int k = 0; k < PTRS; k++) ptr_q[b][k] <= '0;
      end
      for (int k = 0; k < PTRS; k++) pnode_q[k] <= '0;
      tow_q      <= '0;
      stall_q    <= '0;
      pend_q     <= '0;
      pblk_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_type   <= '0;
      rsp_node   <= '0;
      rsp_blk    <= '0;
      trap_valid <= 1'b0;
      trap_write <= 1'b0;
      trap_node  <= '0;
      trap_blk   <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      trap_valid <= 1'b0;
      if (|pend_q) begin
        rsp_valid    <= 1'b1;
        rsp_type     <= R_INV;
        rsp_node     <= pnode_q[pidx];
        rsp_blk      <= pblk_q;
        pend_q[pidx] <= 1'b0;
      end else if (req_valid) begin
        rsp_blk   <= req_blk;
        rsp_node  <= req_node;
        trap_blk  <= req_blk;
        trap_node <= req_node;
        if (req_type == M_RES) begin
          stall_q[req_blk] <= 1'b0;
        end else if (req_type == M_SWW) begin
          st_q[req_blk]      <= S_WT;
          vld_q[req_blk]     <= PTRS'(1);
          ptr_q[req_blk][0]  <= req_node;
          cnt_q[req_blk]     <= req_cnt;
          tow_q[req_blk]     <= 1'b0;
          stall_q[req_blk]   <= 1'b0;
        end else if (stall_q[req_blk]) begin
          if (is_req) begin
            rsp_valid <= 1'b1;
            rsp_type  <= R_BUSY;
          end
        end else begin
          case (st_q[req_blk])
            S_RO: begin
              if (req_type == M_RD) begin
                if (|is_me) begin
                  rsp_valid <= 1'b1;
                  rsp_type  <= R_RDATA;
                end else if (has_free) begin
                  vld_q[req_blk][free_idx] <= 1'b1;
                  ptr_q[req_blk][free_idx] <= req_node;
                  rsp_valid <= 1'b1;
                  rsp_type  <= R_RDATA;
                end else begin
                  trap_valid       <= 1'b1;
                  trap_write       <= 1'b0;
                  vld_q[req_blk]   <= '0;
                  tow_q[req_blk]   <= 1'b1;
                  stall_q[req_blk] <= 1'b1;
                end
              end else if (req_type == M_WR) begin
                if (tow_q[req_blk]) begin
                  trap_valid       <= 1'b1;
                  trap_write       <= 1'b1;
                  stall_q[req_blk] <= 1'b1;
                end else begin
                  vld_q[req_blk]    <= PTRS'(1);
                  ptr_q[req_blk][0] <= req_node;
                  if (others == '0) begin
                    st_q[req_blk] <= S_RW;
                    rsp_valid     <= 1'b1;
                    rsp_type      <= R_WDATA;
                  end else begin
                    st_q[req_blk]  <= S_WT;
                    cnt_q[req_blk] <= n_oth;
                    pend_q         <= others;
                    pblk_q         <= req_blk;
                    for (int k = 0; k < PTRS; k++) pnode_q[k] <= ptr_q[req_blk][k];
                  end
                end
              end
            end
            S_RW: begin
              if (is_req) begin
                rsp_valid <= 1'b1;
                if (req_node == owner) begin
                  rsp_type <= (req_type == M_RD) ? R_RDATA : R_WDATA;
                end else begin
                  rsp_type          <= R_INV;
                  rsp_node          <= owner;
                  ptr_q[req_blk][0] <= req_node;
                  cnt_q[req_blk]    <= CW'(1);
                  st_q[req_blk]     <= (req_type == M_RD) ? S_RT : S_WT;
                end
              end else if (req_type == M_REPM && req_node == owner) begin
                vld_q[req_blk] <= '0;
                st_q[req_blk]  <= S_RO;
              end
            end
            S_WT: begin
              if (is_req) begin
                rsp_valid <= 1'b1;
                rsp_type  <= R_BUSY;
              end else if (req_type == M_ACK && cnt_q[req_blk] > CW'(1)) begin
                cnt_q[req_blk] <= cnt_q[req_blk] - CW'(1);
              end else if (req_type == M_ACK || req_type == M_UPD) begin
                cnt_q[req_blk] <= '0;
                st_q[req_blk]  <= S_RW;
                rsp_valid      <= 1'b1;
                rsp_type       <= R_WDATA;
                rsp_node       <= owner;
              end
            end
            default: begin
              if (is_req) begin
                rsp_valid <= 1'b1;
                rsp_type  <= R_BUSY;
              end else if (req_type == M_ACK || req_type == M_UPD) begin
                cnt_q[req_blk] <= '0;
                vld_q[req_blk] <= PTRS'(1);
                st_q[req_blk]  <= S_RO;
                rsp_valid      <= 1'b1;
                rsp_type       <= R_RDATA;
                rsp_node       <= owner;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/lptr_dir_chk.sv
`timescale 1ns/1ps
module lptr_dir_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_type,
  input logic       rsp_valid,
  input logic [1:0] rsp_type,
  input logic       trap_valid
);
  p_data_from_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_type <= 2'd1) |-> $past(req_valid && req_ready));

  p_drain_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (rsp_valid && rsp_type == 2'd2));

  p_busy_from_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_type == 2'd3) |-> $past(req_valid && req_ready && req_type <= 3'd1));

  p_trap_no_reply_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !rsp_valid);

  p_trap_from_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(req_valid && req_ready && req_type <= 3'd1));
endmodule

bind lptr_dir lptr_dir_chk chk_i (.*);

// File: tb/lptr_dir_tb_top.sv
`timescale 1ns/1ps
module lptr_dir_tb_top;
  localparam int NODES = 4, BLOCKS = 2, PTRS = 2;
  localparam int RD = 0, WR = 1, REPM = 2, UPD = 3, ACK = 4, RES = 5, SWW = 6;
  localparam int RDATA = 0, WDATA = 1, INV = 2, BUSY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_type = '0;
  logic [1:0] req_node = '0;
  logic       req_blk = 1'b0;
  logic [2:0] req_cnt = '0;
  logic rsp_valid, trap_valid, trap_write;
  logic [1:0] rsp_type, rsp_node, trap_node;
  logic rsp_blk, trap_blk;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lptr_dir #(.NODES(NODES), .BLOCKS(BLOCKS), .PTRS(PTRS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_node(req_node), .req_blk(req_blk), .req_cnt(req_cnt),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_node(rsp_node), .rsp_blk(rsp_blk),
    .trap_valid(trap_valid), .trap_write(trap_write), .trap_node(trap_node), .trap_blk(trap_blk));

  function automatic logic [7:0] ex(bit v, int t, int n, int b, bit tr, bit tw);
    return {v, v ? 2'(t) : 2'd0, v ? 2'(n) : 2'd0, v ? 1'(b) : 1'b0, tr, tr ? tw : 1'b0};
  endfunction

  function automatic logic [7:0] obs();
    return {rsp_valid, rsp_valid ? rsp_type : 2'd0, rsp_valid ? rsp_node : 2'd0,
            rsp_valid ? rsp_blk : 1'b0, trap_valid, trap_valid ? trap_write : 1'b0};
  endfunction

  task automatic chk(string rq, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic send(int t, int n, int b, int c = 0);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_type = 3'(t); req_node = 2'(n); req_blk = 1'(b); req_cnt = 3'(c);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic trap_chk(string rq, int n, int b, bit w);
    chk(rq, obs(), ex(0, 0, 0, 0, 1, w));
    if (trap_valid) chk(rq, {5'd0, trap_node, trap_blk}, {5'd0, 2'(n), 1'(b)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {7'd0, req_ready}, 8'd1);
    chk("R1 outputs", obs(), 8'd0);

    send(RD, 1, 0); chk("R2 add n1", obs(), ex(1, RDATA, 1, 0, 0, 0));
    send(RD, 2, 0); chk("R2 add n2", obs(), ex(1, RDATA, 2, 0, 0, 0));
    send(RD, 1, 0); chk("R2 existing sharer", obs(), ex(1, RDATA, 1, 0, 0, 0));
    send(RD, 3, 0); trap_chk("R10 overflow trap", 3, 0, 0);
    send(RD, 0, 1); chk("R13 other block free", obs(), ex(1, RDATA, 0, 1, 0, 0));
    send(RD, 0, 0); chk("R11 stalled read busy", obs(), ex(1, BUSY, 0, 0, 0, 0));
    send(ACK, 2, 0); chk("R11 ack ignored", obs(), 8'd0);
    send(RES, 0, 0); chk("R11 resume", obs(), 8'd0);
    send(RD, 0, 0); chk("R10 pointers emptied a", obs(), ex(1, RDATA, 0, 0, 0, 0));
    send(RD, 2, 0); chk("R10 pointers emptied b", obs(), ex(1, RDATA, 2, 0, 0, 0));
    send(WR, 1, 0); trap_chk("R12 write trap", 1, 0, 1);
    send(WR, 2, 0); chk("R11 stalled write busy", obs(), ex(1, BUSY, 2, 0, 0, 0));
    send(SWW, 1, 0, 2); chk("R12 handler write", obs(), 8'd0);
    send(RD, 3, 0); chk("R7 WT busy", obs(), ex(1, BUSY, 3, 0, 0, 0));
    send(REPM, 1, 0); chk("R7 WT repm ignored", obs(), 8'd0);
    send(ACK, 0, 0); chk("R8 decrement", obs(), 8'd0);
    send(ACK, 2, 0); chk("R8 last ack", obs(), ex(1, WDATA, 1, 0, 0, 0));
    send(RD, 1, 0); chk("R5 owner read", obs(), ex(1, RDATA, 1, 0, 0, 0));
    send(WR, 2, 0); chk("R5 write steal", obs(), ex(1, INV, 1, 0, 0, 0));
    send(UPD, 1, 0); chk("R8 update finish", obs(), ex(1, WDATA, 2, 0, 0, 0));
    send(RD, 3, 0); chk("R5 read steal", obs(), ex(1, INV, 2, 0, 0, 0));
    send(WR, 0, 0); chk("R7 RT busy", obs(), ex(1, BUSY, 0, 0, 0, 0));
    send(ACK, 2, 0); chk("R9 ack finish", obs(), ex(1, RDATA, 3, 0, 0, 0));
    send(WR, 3, 0); chk("R9 sole sharer R3", obs(), ex(1, WDATA, 3, 0, 0, 0));
    send(REPM, 3, 0); chk("R6 owner repm", obs(), 8'd0);
    send(WR, 0, 0); chk("R6 emptied R3", obs(), ex(1, WDATA, 0, 0, 0, 0));
    send(REPM, 1, 0); chk("R6 foreign repm", obs(), 8'd0);
    send(RD, 1, 0); chk("R6 owner kept", obs(), ex(1, INV, 0, 0, 0, 0));
    send(REPM, 0, 0); chk("R7 RT repm ignored", obs(), 8'd0);
    send(UPD, 0, 0); chk("R9 update finish", obs(), ex(1, RDATA, 1, 0, 0, 0));
    send(WR, 1, 0); chk("R12 normal mode restored", obs(), ex(1, WDATA, 1, 0, 0, 0));

    send(WR, 0, 1); chk("R13 block1 sole sharer", obs(), ex(1, WDATA, 0, 1, 0, 0));
    send(REPM, 0, 1); chk("R6 block1 release", obs(), 8'd0);

    for (int a = 0; a < NODES; a++)
      for (int b = 0; b < NODES; b++)
        for (int w = 0; w < NODES; w++) begin
          int nexp;
          int lst[2];
          if (a == b) continue;
          nexp = 0;
          if (a != w) begin lst[nexp] = a; nexp++; end
          if (b != w) begin lst[nexp] = b; nexp++; end
          send(RD, a, 1); chk("R2 sweep a", obs(), ex(1, RDATA, a, 1, 0, 0));
          send(RD, b, 1); chk("R2 sweep b", obs(), ex(1, RDATA, b, 1, 0, 0));
          send(WR, w, 1); chk("R4 no reply on accept", obs(), 8'd0);
          for (int k = 0; k < nexp; k++) begin
            chk("R4 ready held low", {7'd0, req_ready}, 8'd0);
            @(negedge clk);
            chk("R4 invalidate order", obs(), ex(1, INV, lst[k], 1, 0, 0));
          end
          chk("R4 ready restored", {7'd0, req_ready}, 8'd1);
          for (int k = 0; k < nexp; k++) begin
            send(ACK, lst[k], 1);
            if (k == nexp - 1) chk("R8 counter final", obs(), ex(1, WDATA, w, 1, 0, 0));
            else chk("R8 counter step", obs(), 8'd0);
          end
          send(REPM, w, 1); chk("R6 sweep release", obs(), 8'd0);
        end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule